// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Loader

This block is the synchronous digital front end for a two-channel parallel-input converter. A 16-bit word on the data bus is written into the staging register of channel A, channel B, both or neither, as chosen by a 2-bit address. A separate load strobe then moves the staging registers into the output registers that drive the converter. Several channels, or several copies of this block, can therefore change their outputs on the same clock. Each output register is also split for the converter core. Its top four bits become a 15-line thermometer of equally weighted segment enables, and its low twelve bits pass on as the binary ladder code.

All control and data pins are asynchronous to the block clock. They pass through a two-stage synchroniser, and every register decision is made from the synchronised levels on each clock. The data path has no valid/ready stream. A word is taken on every clock on which the synchronised write is active, and no back-pressure exists: the host holds data, address and strobes steady for at least one clock beyond the synchroniser. The active-low clear pin empties the reset synchroniser asynchronously. The registers take the reset value on the next clock and keep it until two clocks after the pin is released. The value is zero or midscale, chosen by a select pin.

Top module: `dual_dac_loader`

## Requirements
- R1: The synchronised address selects the channels that a write reaches: 2'b00 selects channel A, 2'b11 selects channel B, 2'b10 selects both, and 2'b01 selects none. With 2'b01, no staging register changes, even when the strobes call for a transparent transfer.
- R2: While `clr_n` is low, from the first clock edge after it falls, both staging and both output registers hold the reset value, whatever the write and load pins do.
- R3: The reset value is 16'h0000 when `mid_rst` is 0 and 16'h8000 (top bit only) when it is 1.
- R4: With `wr_n` low and `ldac` low, the addressed staging registers take `din` and both output registers keep their value.
- R5: With `wr_n` high and `ldac` high, each output register copies its own channel's staging register.
- R6: With `wr_n` low and `ldac` high, the addressed channels are transparent: `din` reaches their staging and output registers on the same update. A channel that is not addressed copies its own staging register into its output register.
- R7: With `wr_n` high and `ldac` low, no register changes.
- R8: When `wr_n` and `ldac` are driven together as one active-low pulse, the low phase captures `din` into the addressed staging registers, and the return to high transfers it to the output registers.
- R9: Segment bit k of `seg_a`/`seg_b` is 1 exactly when bits [15:12] of that channel's output register, read as an unsigned number, are greater than k (k = 0..14). Code 0 gives 15'h0000 and code 15 gives 15'h7FFF.
- R10: `lsb_a`/`lsb_b` equal bits [11:0] of the matching output register.
- R11: A pin change made before clock edge 1 shows on the outputs after edge 3 (two synchroniser stages plus the register). After `clr_n` rises, edges 1 and 2 still apply the reset value, and edge 3 is the first normal update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| clr_n | input | 1 | Active-low clear; asserts asynchronously, releases synchronously |
| mid_rst | input | 1 | Reset value select: 0 zero, 1 midscale |
| din | input | 16 | Parallel data word |
| addr | input | 2 | Channel select (see R1) |
| wr_n | input | 1 | Active-low write |
| ldac | input | 1 | Load strobe, active high |
| dac_a | output | 16 | Channel A output register |
| dac_b | output | 16 | Channel B output register |
| seg_a | output | 15 | Channel A thermometer segments |
| seg_b | output | 15 | Channel B thermometer segments |
| lsb_a | output | 12 | Channel A binary ladder bits |
| lsb_b | output | 12 | Channel B binary ladder bits |

## Verification
The hardest case to reach from the pins is the two-edge window after `clr_n` rises. In that window the synchronised strobes may already request a transparent write, yet the registers must still show the reset value. The stimulus parks a transparent write to both channels in the synchroniser while clear is held low, then releases clear and samples after the second and third edges. The staging registers cannot be seen directly. Their contents are brought out by a later load strobe, which shows whether an address-none or idle cycle has altered them.

// File: rtl/dac_ld_pkg.sv
package dac_ld_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_NONE = 2'b01,
    SEL_BOTH = 2'b10,
    SEL_B    = 2'b11
  } dac_sel_e;

  // Channel 0 is A, channel 1 is B.
  function automatic logic chan_hit(input logic [1:0] sel, input int ch);
    logic hit;
    case (dac_sel_e'(sel))
      SEL_BOTH: hit = 1'b1;
      SEL_A:    hit = (ch == 0);
      SEL_B:    hit = (ch == 1);
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/dac_ld_sync.sv
module dac_ld_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_ld_rst.sv
module dac_ld_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_act
);
  logic [STAGES-1:0] sh;

  // Clear empties the chain at once; ones walk in after release.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_act = !sh[STAGES-1];
endmodule

// File: rtl/dac_ld_chan.sv
module dac_ld_chan
  import dac_ld_pkg::*;
#(
  parameter int DW = 16,
  parameter int CH = 0
) (
  input  logic          clk,
  input  logic          rst_act,
  input  logic [DW-1:0] rst_val,
  input  logic          wr_act,
  input  logic          ld_act,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] stage_q,
  output logic [DW-1:0] out_q
);
  logic          hit;
  logic [DW-1:0] stage_d;

  always_comb begin
    hit     = chan_hit(sel, CH);
    stage_d = (wr_act && hit) ? din : stage_q;
  end

  // The load takes the next staging value, so write-plus-load is transparent.
  always_ff @(posedge clk) begin
    if (rst_act) begin
      stage_q <= rst_val;
      out_q   <= rst_val;
    end else begin
      stage_q <= stage_d;
      if (ld_act) out_q <= stage_d;
    end
  end
endmodule

// File: rtl/dac_ld_seg.sv
module dac_ld_seg #(
  parameter int DW       = 16,
  parameter int SEG_BITS = 4,
  localparam int NUM_SEG = (1 << SEG_BITS) - 1,
  localparam int BIN_W   = DW - SEG_BITS
) (
  input  logic [DW-1:0]      code,
  output logic [NUM_SEG-1:0] seg,
  output logic [BIN_W-1:0]   lsb
);
  logic [SEG_BITS-1:0] top;

  assign top = code[DW-1 -: SEG_BITS];
  assign lsb = code[BIN_W-1:0];

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    assign seg[k] = (top > SEG_BITS'(k));
  end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dac_ld_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SEG_BITS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SEG    = (1 << SEG_BITS) - 1,
  localparam int BIN_W      = DW - SEG_BITS
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               mid_rst,
  input  logic [DW-1:0]      din,
  input  logic [1:0]         addr,
  input  logic               wr_n,
  input  logic               ldac,
  output logic [DW-1:0]      dac_a,
  output logic [DW-1:0]      dac_b,
  output logic [NUM_SEG-1:0] seg_a,
  output logic [NUM_SEG-1:0] seg_b,
  output logic [BIN_W-1:0]   lsb_a,
  output logic [BIN_W-1:0]   lsb_b
);
  localparam int NCH  = 2;
  localparam int BUNW = DW + 5;
  localparam logic [DW-1:0] MID_VAL = {1'b1, {(DW-1){1'b0}}};

  logic [BUNW-1:0] raw_bus, syn_bus;
  logic            rst_act;
  logic            mid_s, wr_n_s, ldac_s;
  logic [1:0]      addr_s;
  logic [DW-1:0]   din_s, rst_val;

  logic [DW-1:0]      stage_q [NCH];
  logic [DW-1:0]      out_q   [NCH];
  logic [NUM_SEG-1:0] seg_w   [NCH];
  logic [BIN_W-1:0]   lsb_w   [NCH];

  assign raw_bus = {mid_rst, wr_n, ldac, addr, din};

  dac_ld_sync #(.W(BUNW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_bus),
    .q   (syn_bus)
  );

  dac_ld_rst #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .clr_n   (clr_n),
    .rst_act (rst_act)
  );

  assign {mid_s, wr_n_s, ldac_s, addr_s, din_s} = syn_bus;
  assign rst_val = mid_s ? MID_VAL : '0;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dac_ld_chan #(.DW(DW), .CH(ch)) u_chan (
      .clk     (clk),
      .rst_act (rst_act),
      .rst_val (rst_val),
      .wr_act  (!wr_n_s),
      .ld_act  (ldac_s),
      .sel     (addr_s),
      .din     (din_s),
      .stage_q (stage_q[ch]),
      .out_q   (out_q[ch])
    );

    dac_ld_seg #(.DW(DW), .SEG_BITS(SEG_BITS)) u_seg (
      .code (out_q[ch]),
      .seg  (seg_w[ch]),
      .lsb  (lsb_w[ch])
    );
  end

  assign dac_a = out_q[0];
  assign dac_b = out_q[1];
  assign seg_a = seg_w[0];
  assign seg_b = seg_w[1];
  assign lsb_a = lsb_w[0];
  assign lsb_b = lsb_w[1];
endmodule

// File: rtl/dac_ld_chk.sv
module dac_ld_chk #(
  parameter int DW       = 16,
  parameter int SEG_BITS = 4,
  parameter int NUM_SEG  = 15
) (
  input logic               clk,
  input logic               clr_n,
  input logic               rst_act,
  input logic               wr_n_s,
  input logic               ldac_s,
  input logic               mid_s,
  input logic [1:0]         addr_s,
  input logic [DW-1:0]      stg_a,
  input logic [DW-1:0]      stg_b,
  input logic [DW-1:0]      dac_a,
  input logic [DW-1:0]      dac_b,
  input logic [NUM_SEG-1:0] seg_a,
  input logic [NUM_SEG-1:0] seg_b
);
  localparam logic [DW-1:0]      MID = {1'b1, {(DW-1){1'b0}}};
  localparam logic [NUM_SEG-1:0] ONE = NUM_SEG'(1);

  a_r1_none_keeps_stage: assert property (@(posedge clk) disable iff (!clr_n)
    (!rst_act && !wr_n_s && addr_s == 2'b01) |=> ($stable(stg_a) && $stable(stg_b)));

  // R3 as well: the value depends on the synchronised select
  a_r2_reset_value: assert property (@(posedge clk) disable iff (!clr_n)
    rst_act |=> (dac_a == ($past(mid_s) ? MID : '0)) && (dac_b == ($past(mid_s) ? MID : '0)));

  a_r4_load_keeps_out: assert property (@(posedge clk) disable iff (!clr_n)
    (!rst_act && !wr_n_s && !ldac_s) |=> ($stable(dac_a) && $stable(dac_b)));

  a_r5_copy_stage: assert property (@(posedge clk) disable iff (!clr_n)
    (!rst_act && wr_n_s && ldac_s) |=> (dac_a == $past(stg_a)) && (dac_b == $past(stg_b)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (!rst_act && wr_n_s && !ldac_s) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(stg_a) && $stable(stg_b)));

  a_r9_seg_a_shape: assert property (@(posedge clk) disable iff (!clr_n)
    (((seg_a + ONE) & seg_a) == '0) && ($countones(seg_a) == int'(dac_a[DW-1 -: SEG_BITS])));

  a_r9_seg_b_shape: assert property (@(posedge clk) disable iff (!clr_n)
    (((seg_b + ONE) & seg_b) == '0) && ($countones(seg_b) == int'(dac_b[DW-1 -: SEG_BITS])));
endmodule

bind dual_dac_loader dac_ld_chk #(.DW(DW), .SEG_BITS(SEG_BITS), .NUM_SEG(NUM_SEG)) u_chk (
  .clk     (clk),
  .clr_n   (clr_n),
  .rst_act (rst_act),
  .wr_n_s  (wr_n_s),
  .ldac_s  (ldac_s),
  .mid_s   (mid_s),
  .addr_s  (addr_s),
  .stg_a   (stage_q[0]),
  .stg_b   (stage_q[1]),
  .dac_a   (dac_a),
  .dac_b   (dac_b),
  .seg_a   (seg_a),
  .seg_b   (seg_b)
);

// File: tb/dual_dac_loader_tb.sv
module dual_dac_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        clr_n, mid_rst, wr_n, ldac;
  logic [15:0] din;
  logic [1:0]  addr;
  logic [15:0] dac_a, dac_b;
  logic [14:0] seg_a, seg_b;
  logic [11:0] lsb_a, lsb_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_loader u_dut (
    .clk(clk), .clr_n(clr_n), .mid_rst(mid_rst), .din(din), .addr(addr),
    .wr_n(wr_n), .ldac(ldac), .dac_a(dac_a), .dac_b(dac_b),
    .seg_a(seg_a), .seg_b(seg_b), .lsb_a(lsb_a), .lsb_b(lsb_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Behavioural model: pin values delayed two clocks through a queue.
  logic [20:0] pipe [$];
  logic [20:0] cur;
  logic [15:0] m_stage [2];
  logic [15:0] m_out   [2];
  int          rel = 0;
  bit          cmp_en = 1'b0;

  initial begin
    pipe.push_back('0);
    pipe.push_back('0);
    m_stage[0] = '0; m_stage[1] = '0;
    m_out[0]   = '0; m_out[1]   = '0;
  end

  always @(posedge clk) begin
    bit          in_rst, hit;
    logic [15:0] rv;
    cur = pipe.pop_front();
    pipe.push_back({mid_rst, wr_n, ldac, addr, din});
    in_rst = !clr_n || (rel < 2);
    rel = clr_n ? ((rel < 2) ? rel + 1 : 2) : 0;
    rv = cur[20] ? 16'h8000 : 16'h0000;
    for (int ch = 0; ch < 2; ch++) begin
      if (in_rst) begin
        m_stage[ch] = rv;
        m_out[ch]   = rv;
      end else begin
        hit = (cur[17:16] == 2'b10) || (ch == 0 && cur[17:16] == 2'b00) ||
              (ch == 1 && cur[17:16] == 2'b11);
        if (!cur[19] && hit) m_stage[ch] = cur[15:0];
        if (cur[18]) m_out[ch] = m_stage[ch];
      end
    end
    cmp_en = 1'b1;
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R11 dac_a cycle", 32'(dac_a), 32'(m_out[0]));
      chk("R11 dac_b cycle", 32'(dac_b), 32'(m_out[1]));
      chk("R9 seg_a cycle", 32'(seg_a), (32'd1 << m_out[0][15:12]) - 32'd1);
      chk("R9 seg_b cycle", 32'(seg_b), (32'd1 << m_out[1][15:12]) - 32'd1);
      chk("R10 lsb_a cycle", 32'(lsb_a), 32'(m_out[0][11:0]));
      chk("R10 lsb_b cycle", 32'(lsb_b), 32'(m_out[1][11:0]));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(input logic [1:0] a, input logic [15:0] d, input logic w, input logic l);
    addr = a; din = d; wr_n = w; ldac = l;
  endtask

  task automatic load_pulse();
    drv(2'b01, 16'h0, 1'b1, 1'b1); step(1);
    drv(2'b01, 16'h0, 1'b1, 1'b0); step(4);
  endtask

  task automatic write_word(input logic [1:0] a, input logic [15:0] d);
    drv(a, d, 1'b0, 1'b0); step(1);
    drv(a, d, 1'b1, 1'b0); step(4);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog act=timeout exp=finished");
    finish_up();
  end

  initial begin
    clr_n = 1'b0; mid_rst = 1'b0;
    drv(2'b00, 16'h0, 1'b1, 1'b0);
    step(1);
    // R2: clear held while a transparent write is requested
    drv(2'b10, 16'h1234, 1'b0, 1'b1); step(5);
    chk("R2 dac_a under clear", 32'(dac_a), 32'h0000);
    chk("R2 dac_b under clear", 32'(dac_b), 32'h0000);
    // R3: midscale reset value
    mid_rst = 1'b1; step(5);
    chk("R3 dac_a midscale", 32'(dac_a), 32'h8000);
    chk("R3 dac_b midscale", 32'(dac_b), 32'h8000);
    chk("R9 seg_a midscale", 32'(seg_a), 32'h00FF);
    chk("R10 lsb_a midscale", 32'(lsb_a), 32'h000);
    // release with idle strobes
    drv(2'b00, 16'h0, 1'b1, 1'b0); clr_n = 1'b1; step(5);
    chk("R7 idle after release", 32'(dac_a), 32'h8000);
    // R4 then R5
    write_word(2'b00, 16'h1111);
    chk("R4 out holds on input load", 32'(dac_a), 32'h8000);
    load_pulse();
    chk("R5 dac_a copies stage", 32'(dac_a), 32'h1111);
    chk("R1 addr 00 leaves B", 32'(dac_b), 32'h8000);
    // R1 channel B only
    write_word(2'b11, 16'hF00D); load_pulse();
    chk("R1 addr 11 hits B", 32'(dac_b), 32'hF00D);
    chk("R1 addr 11 leaves A", 32'(dac_a), 32'h1111);
    chk("R9 seg_b code 15", 32'(seg_b), 32'h7FFF);
    chk("R10 lsb_b", 32'(lsb_b), 32'h00D);
    // R1 both
    write_word(2'b10, 16'h3ABC); load_pulse();
    chk("R1 addr 10 A", 32'(dac_a), 32'h3ABC);
    chk("R1 addr 10 B", 32'(dac_b), 32'h3ABC);
    chk("R9 seg_a code 3", 32'(seg_a), 32'h0007);
    chk("R10 lsb_a", 32'(lsb_a), 32'hABC);
    // R1 none, transparent request
    drv(2'b01, 16'hDEAD, 1'b0, 1'b1); step(1);
    drv(2'b01, 16'h0, 1'b1, 1'b0); step(4);
    load_pulse();
    chk("R1 addr 01 A untouched", 32'(dac_a), 32'h3ABC);
    chk("R1 addr 01 B untouched", 32'(dac_b), 32'h3ABC);
    // R6 transparent, with R11 edge timing
    drv(2'b00, 16'h5555, 1'b0, 1'b1); step(2);
    chk("R11 not yet after two edges", 32'(dac_a), 32'h3ABC);
    step(1);
    chk("R6 transparent A", 32'(dac_a), 32'h5555);
    chk("R6 unaddressed B", 32'(dac_b), 32'h3ABC);
    drv(2'b00, 16'h0, 1'b1, 1'b0); step(4);
    // R7 idle with moving data
    drv(2'b10, 16'hBEEF, 1'b1, 1'b0); step(1);
    drv(2'b11, 16'h0123, 1'b1, 1'b0); step(4);
    chk("R7 idle A", 32'(dac_a), 32'h5555);
    chk("R7 idle B", 32'(dac_b), 32'h3ABC);
    load_pulse();
    chk("R7 stage A unchanged", 32'(dac_a), 32'h5555);
    chk("R7 stage B unchanged", 32'(dac_b), 32'h3ABC);
    // R8 tied pulse
    drv(2'b11, 16'h0F0F, 1'b0, 1'b0); step(4);
    chk("R8 low phase holds out", 32'(dac_b), 32'h3ABC);
    drv(2'b11, 16'h0F0F, 1'b1, 1'b1); step(4);
    chk("R8 high phase transfers", 32'(dac_b), 32'h0F0F);
    chk("R8 A kept", 32'(dac_a), 32'h5555);
    drv(2'b00, 16'h0, 1'b1, 1'b0); step(4);
    // R2 asynchronous assertion
    clr_n = 1'b0; step(1);
    chk("R2 first edge A", 32'(dac_a), 32'h8000);
    chk("R2 first edge B", 32'(dac_b), 32'h8000);
    mid_rst = 1'b0; step(4);
    chk("R3 zero reset", 32'(dac_a), 32'h0000);
    // R11 release window
    drv(2'b10, 16'h4242, 1'b0, 1'b1); step(4);
    chk("R2 transparent ignored", 32'(dac_b), 32'h0000);
    clr_n = 1'b1; step(2);
    chk("R11 reset through edge 2", 32'(dac_a), 32'h0000);
    step(1);
    chk("R11 first update A", 32'(dac_a), 32'h4242);
    chk("R11 first update B", 32'(dac_b), 32'h4242);
    drv(2'b00, 16'h0, 1'b1, 1'b0); step(3);
    finish_up();
  end
endmodule